// File: doc/BRIEF.md
# Flash Sector Address Generator

This block sits beside the command engine of a NAND-style flash controller. Software writes eight 16-bit start-address registers and one start-buffer register through a simple write port, and can read any of them back through a combinational readback port. When the command engine pulses `cmd_strobe`, the block turns the register contents into the numbers the transfer logic needs. Those numbers are a source sector index, a copy-back destination sector index, the first and last sector of an erase block, a sector count and a buffer pointer with its byte offsets.

Sector numbers assume 2 KB pages of four 512-byte sectors and 64 pages per erase block. A block field is taken from the low twelve bits of a block register. When bit 15 of that register is set and the device identifier enables it, a density mask is ORed in. All results are captured on the strobe edge. They are presented with `out_valid` in the following cycle and held until the next strobe.

The control is a two-state machine. In ST_IDLE the outputs are held and `out_valid` is low. The transition "capture" (strobe seen in ST_IDLE) moves to ST_SHOW. In ST_SHOW `out_valid` is high for that cycle. The transition "recapture" (strobe in ST_SHOW) stays in ST_SHOW. The transition "release" (no strobe in ST_SHOW) returns to ST_IDLE.

Top module: `flash_sector_addr_gen`

## Requirements
- R1: After reset all eight address registers read 0, the start-buffer register reads 0, the sector count is 1, the buffer address is 0 and `out_valid` is low.
- R2: A write with `wr_sel` 0..7 loads the address register of that index. A write with `wr_sel` 8 loads the start-buffer register. A write with `wr_sel` 9..15 changes no register.
- R3: A start-buffer write takes the buffer address from data bits 11:8 and the count from bits 1:0, where field value 0 means 4 sectors. Readback of `rd_sel` 8 returns (buffer address << 8) | ((count - 1) & 2).
- R4: The source sector equals block_field * 256 + reg7[7:2] * 4 + reg7[1:0], where block_field comes from reg0.
- R5: block_field is reg[11:0] ORed, when reg bit 15 is 1 and `device_id` bit 3 is 1, with the mask 1 << (6 + device_id[6:4]). Otherwise the mask is 0.
- R6: The copy-back destination sector uses the same formula with reg2 as block register and reg3 as page register.
- R7: The erase first sector is block_field(reg0) * 256, and the erase last sector is that value plus 255.
- R8: `buf_data_sel` is buffer address bit 3 and `buf_bank` is bit 2. `main_byte_off` is bits 1:0 times 512, and `spare_byte_off` is bits 1:0 times 16.
- R9: `out_valid` is high in exactly the cycle after each strobe cycle. All result outputs change only in that cycle and hold their values when no strobe occurs, even if registers are rewritten.
- R10: A register write in the same cycle as a strobe does not affect that strobe's results. It does affect the results of a strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| device_id | input | 16 | Device identifier; bit 3 enables density mask, bits 6:4 size it |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Write register select (0..7 address, 8 start buffer) |
| wr_data | input | 16 | Write data |
| rd_sel | input | 4 | Readback register select |
| rd_data | output | 16 | Readback data (combinational) |
| cmd_strobe | input | 1 | Command issue pulse; captures results |
| out_valid | output | 1 | High the cycle after a strobe |
| main_sector | output | 24 | Source sector index |
| dest_sector | output | 24 | Copy-back destination sector index |
| erase_first | output | 24 | First sector of the erase block |
| erase_last | output | 24 | Last sector of the erase block |
| sec_count | output | 3 | Sector count, 1..4 |
| buf_data_sel | output | 1 | 1 selects a data buffer, 0 the boot buffer |
| buf_bank | output | 1 | Data buffer bank |
| main_byte_off | output | 11 | Main-area byte offset in the buffer |
| spare_byte_off | output | 6 | Spare-area byte offset in the buffer |

## Verification
The hardest situation to reach from the ports is a register write landing in the same cycle as a strobe, followed at once by a second strobe. Here the first capture must see the old value and the second the new one, and `out_valid` must stay high across both cycles. The stimulus drives a write and a strobe together and keeps the strobe high for one more cycle. A queue of predictions made before each write separates the two results. The density-mask path needs both block bit 15 and device-identifier bit 3. It is exercised with several mask sizes, including the largest, and with bit 3 cleared while bit 15 stays set.

// File: rtl/fsag_pkg.sv
package fsag_pkg;

    localparam int REG_W       = 16;
    localparam int NUM_AREGS   = 8;
    localparam int SEL_W       = 4;
    localparam int SBUF_SEL    = NUM_AREGS;

    localparam int BLK_BITS    = 12;
    localparam int PG_SEC_LOG2 = 2;
    localparam int BLK_PG_LOG2 = 6;
    localparam int PG_FLD_W    = BLK_PG_LOG2;
    localparam int DENS_BASE   = 6;
    localparam int DENS_SEL_W  = 3;
    localparam int FIELD_W     = DENS_BASE + (1 << DENS_SEL_W) + 1;
    localparam int SEC_W       = 24;
    localparam int ERASE_SECT  = 1 << (BLK_PG_LOG2 + PG_SEC_LOG2);

    localparam int SRC_BLK_IDX = 0;
    localparam int SRC_PG_IDX  = 7;
    localparam int DST_BLK_IDX = 2;
    localparam int DST_PG_IDX  = 3;

    localparam int CNT_FLD_W   = PG_SEC_LOG2;
    localparam int CNT_W       = CNT_FLD_W + 1;
    localparam int MAX_CNT     = 1 << CNT_FLD_W;
    localparam int RB_CNT_MASK = 1 << (CNT_FLD_W - 1);

    localparam int BUF_LSB     = 8;
    localparam int BUF_W       = 4;
    localparam int BUF_OFF_W   = 2;
    localparam int SECT_BYTES_LOG2  = 9;
    localparam int SPARE_BYTES_LOG2 = 4;
    localparam int MOFF_W      = BUF_OFF_W + SECT_BYTES_LOG2;
    localparam int SOFF_W      = BUF_OFF_W + SPARE_BYTES_LOG2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } fsag_state_e;

    function automatic logic [FIELD_W-1:0] blk_field(
        input logic [REG_W-1:0] blk,
        input logic [REG_W-1:0] id
    );
        logic [FIELD_W-1:0] mask;
        mask = '0;
        if (id[3]) begin
            mask = FIELD_W'(1) << (DENS_BASE + int'(id[6:4]));
        end
        return FIELD_W'(blk[BLK_BITS-1:0]) | (blk[REG_W-1] ? mask : '0);
    endfunction

endpackage

// File: rtl/fsag_regfile.sv
module fsag_regfile
    import fsag_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SEL_W-1:0]                 wr_sel,
    input  logic [REG_W-1:0]                 wr_data,
    input  logic [SEL_W-1:0]                 rd_sel,
    output logic [REG_W-1:0]                 rd_data,
    output logic [NUM_AREGS-1:0][REG_W-1:0]  aregs_o,
    output logic [BUF_W-1:0]                 bufaddr_o,
    output logic [CNT_W-1:0]                 count_o
);

    localparam int AIDX_W = $clog2(NUM_AREGS);

    logic [NUM_AREGS-1:0][REG_W-1:0] aregs_q;
    logic [BUF_W-1:0]                bufaddr_q;
    logic [CNT_W-1:0]                count_q;
    logic [CNT_FLD_W-1:0]            cnt_field;
    logic [CNT_W-1:0]                cnt_m1;

    assign cnt_field = wr_data[CNT_FLD_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_AREGS; i++) begin
                aregs_q[i] <= '0;
            end
            bufaddr_q <= '0;
            count_q   <= CNT_W'(1);
        end else if (wr_en) begin
            if (wr_sel < SEL_W'(NUM_AREGS)) begin
                aregs_q[wr_sel[AIDX_W-1:0]] <= wr_data;
            end else if (wr_sel == SEL_W'(SBUF_SEL)) begin
                bufaddr_q <= wr_data[BUF_LSB +: BUF_W];
                count_q   <= (cnt_field == '0) ? CNT_W'(MAX_CNT)
                                               : CNT_W'(cnt_field);
            end
        end
    end

    assign cnt_m1 = count_q - CNT_W'(1);

    always_comb begin
        rd_data = '0;
        if (rd_sel < SEL_W'(NUM_AREGS)) begin
            rd_data = aregs_q[rd_sel[AIDX_W-1:0]];
        end else if (rd_sel == SEL_W'(SBUF_SEL)) begin
            rd_data = (REG_W'(bufaddr_q) << BUF_LSB)
                    | REG_W'(cnt_m1 & CNT_W'(RB_CNT_MASK));
        end
    end

    assign aregs_o   = aregs_q;
    assign bufaddr_o = bufaddr_q;
    assign count_o   = count_q;

    // R3: the held count never leaves 1..MAX_CNT
    a_r3_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q >= CNT_W'(1)) && (count_q <= CNT_W'(MAX_CNT)));

    // R2: writes to unmapped selects leave every register untouched
    a_r2_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel > SEL_W'(SBUF_SEL)))
        |=> ($stable(aregs_q) && $stable(bufaddr_q) && $stable(count_q)));

endmodule

// File: rtl/fsag_sector_calc.sv
module fsag_sector_calc
    import fsag_pkg::*;
(
    input  logic [REG_W-1:0] blk_reg,
    input  logic [REG_W-1:0] page_reg,
    input  logic [REG_W-1:0] device_id,
    output logic [SEC_W-1:0] sector
);

    logic [FIELD_W-1:0]     field;
    logic [PG_FLD_W-1:0]    page_idx;
    logic [PG_SEC_LOG2-1:0] sec_in_page;
    logic                   unused_page_hi;

    assign field       = blk_field(blk_reg, device_id);
    assign page_idx    = page_reg[PG_SEC_LOG2 +: PG_FLD_W];
    assign sec_in_page = page_reg[PG_SEC_LOG2-1:0];
    assign unused_page_hi = ^page_reg[REG_W-1:PG_SEC_LOG2+PG_FLD_W];

    assign sector = SEC_W'(sec_in_page)
                  + ((SEC_W'(page_idx) + (SEC_W'(field) << BLK_PG_LOG2))
                     << PG_SEC_LOG2);

endmodule

// File: rtl/fsag_erase_calc.sv
module fsag_erase_calc
    import fsag_pkg::*;
(
    input  logic [REG_W-1:0] blk_reg,
    input  logic [REG_W-1:0] device_id,
    output logic [SEC_W-1:0] erase_first,
    output logic [SEC_W-1:0] erase_last
);

    localparam int ERASE_SHIFT = BLK_PG_LOG2 + PG_SEC_LOG2;

    logic [FIELD_W-1:0] field;

    assign field       = blk_field(blk_reg, device_id);
    assign erase_first = SEC_W'(field) << ERASE_SHIFT;
    assign erase_last  = erase_first + SEC_W'(ERASE_SECT - 1);

endmodule

// File: rtl/fsag_ctrl.sv
module fsag_ctrl
    import fsag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_strobe,
    input  logic [SEC_W-1:0]  src_sector,
    input  logic [SEC_W-1:0]  dst_sector,
    input  logic [SEC_W-1:0]  ers_first,
    input  logic [SEC_W-1:0]  ers_last,
    input  logic [BUF_W-1:0]  bufaddr,
    input  logic [CNT_W-1:0]  count,
    output logic              out_valid,
    output logic [SEC_W-1:0]  main_sector_o,
    output logic [SEC_W-1:0]  dest_sector_o,
    output logic [SEC_W-1:0]  erase_first_o,
    output logic [SEC_W-1:0]  erase_last_o,
    output logic [CNT_W-1:0]  sec_count_o,
    output logic              buf_data_sel_o,
    output logic              buf_bank_o,
    output logic [MOFF_W-1:0] main_byte_off_o,
    output logic [SOFF_W-1:0] spare_byte_off_o
);

    fsag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_strobe) state_d = ST_SHOW;   // capture
            ST_SHOW: if (!cmd_strobe) state_d = ST_IDLE;  // release / recapture
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_sector_o    <= '0;
            dest_sector_o    <= '0;
            erase_first_o    <= '0;
            erase_last_o     <= SEC_W'(ERASE_SECT - 1);
            sec_count_o      <= '0;
            buf_data_sel_o   <= 1'b0;
            buf_bank_o       <= 1'b0;
            main_byte_off_o  <= '0;
            spare_byte_off_o <= '0;
        end else if (cmd_strobe) begin
            main_sector_o    <= src_sector;
            dest_sector_o    <= dst_sector;
            erase_first_o    <= ers_first;
            erase_last_o     <= ers_last;
            sec_count_o      <= count;
            buf_data_sel_o   <= bufaddr[BUF_W-1];
            buf_bank_o       <= bufaddr[BUF_W-2];
            main_byte_off_o  <= MOFF_W'(bufaddr[BUF_OFF_W-1:0]) << SECT_BYTES_LOG2;
            spare_byte_off_o <= SOFF_W'(bufaddr[BUF_OFF_W-1:0]) << SPARE_BYTES_LOG2;
        end
    end

    assign out_valid = (state_q == ST_SHOW);

    // R9: a strobe is always answered by out_valid in the next cycle
    a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> out_valid);

    // R9: no strobe, no valid
    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_strobe |=> !out_valid);

    // R9: results hold while no strobe arrives
    a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_strobe |=> ($stable(main_sector_o) && $stable(dest_sector_o)
                         && $stable(sec_count_o) && $stable(main_byte_off_o)));

    // R7: erase window spans exactly one block of sectors
    a_r7_erase_span: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((erase_last_o - erase_first_o) == SEC_W'(ERASE_SECT - 1)));

endmodule

// File: rtl/flash_sector_addr_gen.sv
module flash_sector_addr_gen
    import fsag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  device_id,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [REG_W-1:0]  rd_data,
    input  logic              cmd_strobe,
    output logic              out_valid,
    output logic [SEC_W-1:0]  main_sector,
    output logic [SEC_W-1:0]  dest_sector,
    output logic [SEC_W-1:0]  erase_first,
    output logic [SEC_W-1:0]  erase_last,
    output logic [CNT_W-1:0]  sec_count,
    output logic              buf_data_sel,
    output logic              buf_bank,
    output logic [MOFF_W-1:0] main_byte_off,
    output logic [SOFF_W-1:0] spare_byte_off
);

    localparam int NUM_CALC = 2;

    logic [NUM_AREGS-1:0][REG_W-1:0] aregs;
    logic [BUF_W-1:0]                bufaddr;
    logic [CNT_W-1:0]                count;
    logic [NUM_CALC-1:0][SEC_W-1:0]  calc_sector;
    logic [SEC_W-1:0]                ers_first;
    logic [SEC_W-1:0]                ers_last;

    fsag_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .aregs_o   (aregs),
        .bufaddr_o (bufaddr),
        .count_o   (count)
    );

    for (genvar g = 0; g < NUM_CALC; g++) begin : g_calc
        localparam int BI = (g == 0) ? SRC_BLK_IDX : DST_BLK_IDX;
        localparam int PI = (g == 0) ? SRC_PG_IDX  : DST_PG_IDX;
        fsag_sector_calc u_calc (
            .blk_reg   (aregs[BI]),
            .page_reg  (aregs[PI]),
            .device_id (device_id),
            .sector    (calc_sector[g])
        );
    end

    fsag_erase_calc u_erase (
        .blk_reg     (aregs[SRC_BLK_IDX]),
        .device_id   (device_id),
        .erase_first (ers_first),
        .erase_last  (ers_last)
    );

    fsag_ctrl u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_strobe       (cmd_strobe),
        .src_sector       (calc_sector[0]),
        .dst_sector       (calc_sector[1]),
        .ers_first        (ers_first),
        .ers_last         (ers_last),
        .bufaddr          (bufaddr),
        .count            (count),
        .out_valid        (out_valid),
        .main_sector_o    (main_sector),
        .dest_sector_o    (dest_sector),
        .erase_first_o    (erase_first),
        .erase_last_o     (erase_last),
        .sec_count_o      (sec_count),
        .buf_data_sel_o   (buf_data_sel),
        .buf_bank_o       (buf_bank),
        .main_byte_off_o  (main_byte_off),
        .spare_byte_off_o (spare_byte_off)
    );

endmodule

// File: tb/flash_sector_addr_gen_test.sv
`timescale 1ns/1ps
module flash_sector_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] device_id = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        cmd_strobe = 1'b0;
    logic        out_valid;
    logic [23:0] main_sector, dest_sector, erase_first, erase_last;
    logic [2:0]  sec_count;
    logic        buf_data_sel, buf_bank;
    logic [10:0] main_byte_off;
    logic [5:0]  spare_byte_off;

    always #10 clk = ~clk;

    flash_sector_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .device_id(device_id),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .cmd_strobe(cmd_strobe), .out_valid(out_valid),
        .main_sector(main_sector), .dest_sector(dest_sector),
        .erase_first(erase_first), .erase_last(erase_last),
        .sec_count(sec_count), .buf_data_sel(buf_data_sel),
        .buf_bank(buf_bank), .main_byte_off(main_byte_off),
        .spare_byte_off(spare_byte_off)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_push   = 0;
    int n_pop    = 0;

    typedef struct {
        logic [23:0] msec, dsec, efirst, elast;
        int          cnt;
        bit          isdata, bank;
        int          moff, soff;
        string       tag;
    } exp_t;

    exp_t sb[$];
    exp_t got;

    logic [15:0] m_regs [8];
    logic [3:0]  m_buf;
    int          m_cnt;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int field_of(input logic [15:0] b);
        int f;
        f = int'(b & 16'h0FFF);
        if (b[15] && device_id[3]) f = f | (1 << (6 + int'(device_id[6:4])));
        return f;
    endfunction

    function automatic logic [23:0] sector_of(input logic [15:0] b, input logic [15:0] p);
        return 24'(field_of(b) * 256 + int'((p >> 2) & 16'h3F) * 4 + int'(p & 16'h3));
    endfunction

    function automatic exp_t predict(input string tag);
        exp_t e;
        e.msec   = sector_of(m_regs[0], m_regs[7]);
        e.dsec   = sector_of(m_regs[2], m_regs[3]);
        e.efirst = 24'(field_of(m_regs[0]) * 256);
        e.elast  = e.efirst + 24'd255;
        e.cnt    = m_cnt;
        e.isdata = m_buf[3];
        e.bank   = m_buf[2];
        e.moff   = int'(m_buf[1:0]) * 512;
        e.soff   = int'(m_buf[1:0]) * 16;
        e.tag    = tag;
        return e;
    endfunction

    // one clock cycle of stimulus, entered and left just after a falling edge
    task automatic cyc(input bit we, input logic [3:0] sel, input logic [15:0] d,
                       input bit stb, input string tag);
        wr_en = we; wr_sel = sel; wr_data = d; cmd_strobe = stb;
        if (stb) begin
            sb.push_back(predict(tag));
            n_push++;
        end
        if (we) begin
            if (sel < 4'd8) m_regs[sel[2:0]] = d;
            else if (sel == 4'd8) begin
                m_buf = d[11:8];
                m_cnt = (d[1:0] == 2'd0) ? 4 : int'(d[1:0]);
            end
        end
        @(negedge clk);
        wr_en = 1'b0; cmd_strobe = 1'b0;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [15:0] d);
        cyc(1'b1, sel, d, 1'b0, "");
    endtask

    task automatic strobe(input string tag);
        cyc(1'b0, 4'd0, 16'd0, 1'b1, tag);
        @(negedge clk);
    endtask

    task automatic readback(input logic [3:0] sel, input logic [15:0] exp, input string req);
        rd_sel = sel;
        #1;
        check(req, 32'(rd_data), 32'(exp));
    endtask

    function automatic logic [15:0] sbuf_rb();
        return {4'b0, m_buf, 8'b0} | 16'((m_cnt - 1) & 2);
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check("R9 unexpected valid", 32'd1, 32'd0);
            end else begin
                got = sb.pop_front();
                n_pop++;
                check({got.tag, " R4 main_sector"},   32'(main_sector),    32'(got.msec));
                check({got.tag, " R6 dest_sector"},   32'(dest_sector),    32'(got.dsec));
                check({got.tag, " R7 erase_first"},   32'(erase_first),    32'(got.efirst));
                check({got.tag, " R7 erase_last"},    32'(erase_last),     32'(got.elast));
                check({got.tag, " R3 sec_count"},     32'(sec_count),      32'(got.cnt));
                check({got.tag, " R8 buf_data_sel"},  32'(buf_data_sel),   32'(got.isdata));
                check({got.tag, " R8 buf_bank"},      32'(buf_bank),       32'(got.bank));
                check({got.tag, " R8 main_byte_off"}, 32'(main_byte_off),  32'(got.moff));
                check({got.tag, " R8 spare_byte_off"},32'(spare_byte_off), 32'(got.soff));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    logic [23:0] held;

    initial begin
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        m_buf = '0;
        m_cnt = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 out_valid low", 32'(out_valid), 32'd0);
        for (int i = 0; i < 8; i++) readback(4'(i), 16'h0000, "R1 addr reg");
        readback(4'd8, 16'h0000, "R1 start buffer");
        strobe("R1 reset strobe");

        // R2/R4/R8: plain transfer
        wr(4'd0, 16'h0123);
        wr(4'd7, 16'h00B6);
        wr(4'd8, 16'h0A03);
        readback(4'd0, 16'h0123, "R2 reg0");
        readback(4'd7, 16'h00B6, "R2 reg7");
        readback(4'd8, sbuf_rb(), "R3 readback count3");
        strobe("R4 transfer");

        // R3: count field 0 means 4
        wr(4'd8, 16'h0F00);
        readback(4'd8, 16'h0F02, "R3 readback count4");
        strobe("R3 count4");
        wr(4'd8, 16'h0301);
        readback(4'd8, 16'h0300, "R3 readback count1");
        strobe("R8 boot buffer");
        wr(4'd8, 16'h0C02);
        strobe("R8 bank1");

        // R5: density mask
        device_id = 16'h0058;
        wr(4'd0, 16'h8005);
        strobe("R5 mask bit11");
        device_id = 16'h0050;
        strobe("R5 no mask id bit3 clear");
        device_id = 16'h0078;
        wr(4'd0, 16'h8FFF);
        wr(4'd7, 16'h00FF);
        strobe("R5 max mask");
        device_id = 16'h0058;
        wr(4'd0, 16'h0005);
        strobe("R5 no mask bit15 clear");

        // R6: copy-back destination
        wr(4'd2, 16'h8040);
        wr(4'd3, 16'h0007);
        readback(4'd2, 16'h8040, "R2 reg2");
        readback(4'd3, 16'h0007, "R2 reg3");
        strobe("R6 dest");

        // R2: unmapped selects ignored
        for (int s = 9; s < 16; s++) wr(4'(s), 16'hFFFF);
        for (int i = 0; i < 8; i++) readback(4'(i), m_regs[i], "R2 unmapped write");
        readback(4'd8, sbuf_rb(), "R2 unmapped sbuf");
        strobe("R2 after unmapped");

        // R10: write in strobe cycle, then back-to-back strobe
        cyc(1'b1, 4'd7, 16'h0021, 1'b1, "R10 old value");
        cyc(1'b0, 4'd0, 16'h0000, 1'b1, "R10 new value");
        check("R9 valid in second cycle", 32'(out_valid), 32'd1);
        @(negedge clk);

        // R9: hold without strobe
        check("R9 valid dropped", 32'(out_valid), 32'd0);
        held = main_sector;
        wr(4'd0, 16'h0777);
        check("R9 hold valid low", 32'(out_valid), 32'd0);
        wr(4'd7, 16'h0013);
        check("R9 hold sector", 32'(main_sector), 32'(held));
        wr(4'd8, 16'h0800);
        check("R9 hold sector 2", 32'(main_sector), 32'(held));
        strobe("R9 after hold");

        repeat (2) @(negedge clk);
        check("R9 all results seen", 32'(n_pop), 32'(n_push));
        check("R9 queue empty", 32'(sb.size()), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule